// File: doc/BRIEF.md
# Sector Erase Command Buffer

This block gathers sector-erase requests for a small eight-sector flash memory model and runs the erase by itself once the requests stop arriving. Each request is a decoded command strobe that carries a sector index. The block ORs that sector into a selection mask and restarts a quiet-time counter. When the counter runs out with no new request, the block takes over the internal array. It first pre-programs every word of each selected sector to all zeros. It then erases every word of each selected sector to all ones. In both passes the selected sectors are visited in ascending index order, and unselected sectors are skipped.

The host provides no timing once requests stop. It may program words while the block is idle, and it reads through a single read port. While the block is busy, a read at an address inside a selected sector returns a status byte instead of array data. A read anywhere else returns stored data. When the work finishes, the block drops busy, pulses done for one cycle, clears the mask and goes back to plain read behaviour. Word count per sector must be a power of two, because an address is the sector index followed by the word offset.

Top module: `sector_erase_queue`

## Requirements
- R1: After reset, busy and done are 0 and every word of the array reads as all ones.
- R2: While busy is 0, a program strobe stores the bitwise AND of the old word and the write data, as a flash cell that can only clear bits. A later read of that address returns the result.
- R3: A sector-erase strobe is taken while no pre-program or erase pass is running. It ORs bit `cmd_sector` into the mask, in any order and with repeats allowed. busy is 1 from the cycle after the first strobe.
- R4: The pre-program pass starts exactly TIMEOUT clock edges after the last taken strobe. A strobe taken inside that window restarts the count.
- R5: The pre-program pass takes one cycle per word of each selected sector, and the erase pass does the same. busy therefore falls TIMEOUT + 2·WPS·(number of selected sectors) edges after the last strobe. Every word of each selected sector then reads as all ones.
- R6: Words in sectors that are not selected keep their contents through the whole operation.
- R7: While busy, a read in a selected sector returns a status byte with bit DW-1 = 0, bits DW-3..0 = 0, and bit DW-2 toggling after every read strobe to such an address. Reads at addresses outside the selected sectors return stored data.
- R8: done is a one-cycle pulse in the cycle where busy first reads 0. The mask is cleared at the same time, so the next operation starts from an empty selection.
- R9: Sector-erase strobes that arrive during the pre-program or erase pass are ignored. They add no sector and do not change the finishing time.
- R10: Program strobes are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded sector-erase command strobe |
| cmd_sector | input | $clog2(NSEC) | Sector index of the command |
| wr_en | input | 1 | Program strobe |
| wr_addr | input | $clog2(NSEC)+$clog2(WPS) | Program address {sector, offset} |
| wr_data | input | DW | Program data (ANDed into the word) |
| rd_en | input | 1 | Read strobe (advances the toggle bit while busy) |
| rd_addr | input | $clog2(NSEC)+$clog2(WPS) | Read address {sector, offset} |
| rd_data | output | DW | Array data or status byte |
| busy | output | 1 | Request window or erase in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench counts edges from the last command to the fall of busy. That count catches a timer that is off by one, a timer that fails to restart on a repeated command, and a walk that visits unselected sectors or stops early. It sends commands during the erase passes: a design that accepted them would erase an extra sector, or finish late. It runs a second operation right after a first one: a mask left uncleared would wipe sectors from the earlier operation. It also polls inside and outside the selected sectors: a design that got the status rule wrong would return stale data, or would stop toggling bit DW-2 between polls.

// File: rtl/sector_erase_queue.sv
module sector_erase_queue #(
  parameter int NSEC    = 8,
  parameter int WPS     = 4,
  parameter int DW      = 8,
  parameter int TIMEOUT = 20,
  localparam int SW = $clog2(NSEC),
  localparam int OW = $clog2(WPS),
  localparam int AW = SW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [SW-1:0] cmd_sector,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done
);
  localparam int CW    = $clog2(TIMEOUT + 1);
  localparam int DEPTH = NSEC * WPS;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_WAIT = 2'd1, PH_PRE = 2'd2, PH_ERA = 2'd3;

  logic [1:0]      ph_q;
  logic [NSEC-1:0] mask;
  logic [CW-1:0]   tmr;
  logic [SW-1:0]   sec;
  logic [OW-1:0]   off;
  logic            tog;
  logic [DW-1:0]   mem [DEPTH];

  function automatic logic [SW:0] pick(input logic [NSEC-1:0] m, input logic [SW:0] from);
    logic [SW:0] r;
    r = '0;
    for (int i = 0; i < NSEC; i++)
      if (!r[SW] && m[i] && ((SW+1)'(i) >= from)) r = {1'b1, SW'(i)};
    return r;
  endfunction

  logic [SW:0] first_sel, next_sel;
  assign first_sel = pick(mask, '0);
  assign next_sel  = pick(mask, {1'b0, sec} + 1'b1);

  wire [AW-1:0] cur      = {sec, off};
  wire          last_off = (off == OW'(WPS - 1));
  wire          cmd_take = cmd_valid && (ph_q == PH_IDLE || ph_q == PH_WAIT);
  wire          hit      = mask[rd_addr[AW-1:OW]];

  assign busy    = (ph_q != PH_IDLE);
  assign rd_data = (busy && hit) ? {1'b0, tog, {(DW-2){1'b0}}} : mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      mask <= '0;
      tmr  <= '0;
      sec  <= '0;
      off  <= '0;
      tog  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rd_en && busy && hit) tog <= ~tog;
      if (cmd_take) begin
        mask[cmd_sector] <= 1'b1;
        tmr  <= CW'(TIMEOUT - 1);
        ph_q <= PH_WAIT;
      end else if (ph_q == PH_WAIT) begin
        if (tmr != '0) tmr <= tmr - 1'b1;
        else begin
          ph_q <= PH_PRE;
          sec  <= first_sel[SW-1:0];
          off  <= '0;
        end
      end else if (ph_q == PH_PRE || ph_q == PH_ERA) begin
        off <= off + 1'b1;
        if (last_off) begin
          off <= '0;
          if (next_sel[SW]) sec <= next_sel[SW-1:0];
          else if (ph_q == PH_PRE) begin
            ph_q <= PH_ERA;
            sec  <= first_sel[SW-1:0];
          end else begin
            ph_q <= PH_IDLE;
            mask <= '0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (ph_q == PH_PRE) begin
      mem[cur] <= '0;
    end else if (ph_q == PH_ERA) begin
      mem[cur] <= '1;
    end else if (wr_en && !busy) begin
      mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end
endmodule

// File: rtl/sector_erase_queue_chk.sv
module sector_erase_queue_chk #(
  parameter int NSEC    = 8,
  parameter int WPS     = 4,
  parameter int DW      = 8,
  parameter int TIMEOUT = 20,
  localparam int SW = $clog2(NSEC),
  localparam int OW = $clog2(WPS),
  localparam int AW = SW + OW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            busy,
  input logic            done,
  input logic [AW-1:0]   rd_addr,
  input logic [DW-1:0]   rd_data,
  input logic [NSEC-1:0] mask,
  input logic [1:0]      ph_q
);
  localparam logic [1:0] PH_IDLE = 2'd0, PH_WAIT = 2'd1, PH_PRE = 2'd2, PH_ERA = 2'd3;

  logic [15:0] quiet;
  always_ff @(posedge clk) begin
    if (!rst_n) quiet <= '0;
    else if (cmd_valid && (ph_q == PH_IDLE || ph_q == PH_WAIT)) quiet <= '0;
    else if (quiet != 16'hFFFF) quiet <= quiet + 1'b1;
  end

  a_r3_cmd_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  a_r4_start_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PRE && $past(ph_q) == PH_WAIT) |-> (quiet == 16'(TIMEOUT)));

  a_r7_poll_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mask[rd_addr[AW-1:OW]]) |-> !rd_data[DW-1]);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && mask == '0));

  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PRE || ph_q == PH_ERA) |=> (mask == $past(mask) || mask == '0));
endmodule

bind sector_erase_queue sector_erase_queue_chk #(
  .NSEC(NSEC), .WPS(WPS), .DW(DW), .TIMEOUT(TIMEOUT)
) u_chk (.*);

// File: tb/sector_erase_queue_bench.sv
module sector_erase_queue_bench;
  localparam int NSEC = 8, WPS = 4, DW = 8, TIMEOUT = 20;
  localparam int SW = $clog2(NSEC), OW = $clog2(WPS), AW = SW + OW, DEPTH = NSEC * WPS;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, wr_en = 0, rd_en = 0;
  logic [SW-1:0] cmd_sector = '0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic busy, done;

  int total = 0, bad = 0;
  logic [DW-1:0] model [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  sector_erase_queue #(.NSEC(NSEC), .WPS(WPS), .DW(DW), .TIMEOUT(TIMEOUT)) u_sector_erase_queue (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sector(cmd_sector),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done));

  function automatic int exp_cycles(input logic [NSEC-1:0] m);
    return TIMEOUT + 2 * WPS * $countones(m);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (!busy) model[a] = model[a] & d;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en = 1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
  endtask

  task automatic cmd(input logic [SW-1:0] s);
    cmd_valid = 1; cmd_sector = s;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic measure(input int expn, input string req);
    int n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (busy && n < 5000);
    check(n == expn, req, n, expn);
    check(done == 1'b1, "R8 done at busy fall", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  task automatic erase_model(input logic [NSEC-1:0] m);
    for (int i = 0; i < DEPTH; i++) if (m[i / WPS]) model[i] = '1;
  endtask

  task automatic check_all(input string req);
    logic [DW-1:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), d);
      check(d == model[i], req, d, model[i]);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d, d2;
    logic [NSEC-1:0] m;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(done == 0, "R1 done after reset", done, 0);
    check_all("R1 erased after reset");

    for (int i = 0; i < DEPTH; i++) prog(AW'(i), DW'($urandom));
    prog(AW'(3), 8'hF0);
    check_all("R2 program readback");

    // directed: sectors 5,2,5 with restarts, polling and blocked write
    cmd(3'd5);
    check(busy == 1, "R3 busy after first command", busy, 1);
    rd({3'd5, 2'd1}, d);
    rd({3'd5, 2'd2}, d2);
    check(d[DW-1] == 0 && d[DW-3:0] == 0, "R7 status byte", d, {1'b0, d[DW-2], 6'b0});
    check(d[DW-2] != d2[DW-2], "R7 toggle bit", d2[DW-2], ~d[DW-2]);
    rd({3'd0, 2'd1}, d);
    check(d == model[{3'd0, 2'd1}], "R7 outside read returns data", d, model[{3'd0, 2'd1}]);
    prog({3'd0, 2'd1}, 8'h00);
    repeat (TIMEOUT - 8) @(negedge clk);
    cmd(3'd2);
    repeat (TIMEOUT - 2) @(negedge clk);
    cmd(3'd5);
    measure(exp_cycles(8'b0010_0100), "R4 R5 timeout restart and walk");
    erase_model(8'b0010_0100);
    check_all("R5 R6 R10 contents after erase");

    // R9: command during erase ignored
    prog({3'd7, 2'd0}, 8'h5A);
    cmd(3'd1);
    repeat (TIMEOUT + 1) @(negedge clk);
    cmd(3'd7);
    measure(exp_cycles(8'b0000_0010) - TIMEOUT - 2, "R9 late command no delay");
    erase_model(8'b0000_0010);
    check_all("R9 late sector untouched");

    // R8: mask cleared between operations
    prog({3'd2, 2'd0}, 8'h3C);
    cmd(3'd3);
    measure(exp_cycles(8'b0000_1000), "R8 fresh mask timing");
    erase_model(8'b0000_1000);
    rd({3'd2, 2'd0}, d);
    check(d == 8'h3C, "R8 earlier sector kept", d, 8'h3C);

    // random rounds
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 8; k++) prog(AW'($urandom_range(DEPTH - 1)), DW'($urandom));
      m = '0;
      for (int k = 0; k < 1 + $urandom_range(5); k++) begin
        logic [SW-1:0] s;
        s = SW'($urandom_range(NSEC - 1));
        m[s] = 1'b1;
        if (k != 0) repeat ($urandom_range(TIMEOUT - 2)) @(negedge clk);
        cmd(s);
      end
      measure(exp_cycles(m), "R4 R5 random set");
      erase_model(m);
      check_all("R5 R6 random contents");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule